// File: doc/BRIEF.md
# PLL Channel Post-Divider

This block derives one output channel from a parent PLL. The parent's output is presented as a single-cycle strobe in the fast system clock domain, and the channel's output is a strobe in the same domain. Each qualifying parent strobe advances an internal count. Once the count reaches the total divisor, the block emits one output strobe and starts counting again. The total divisor is the programmed integer ratio multiplied by a fixed post-divider that is set when the block is built.

The channel has a small control register. It holds an integer ratio field and a switch-off bit. A separate hold input also gates the channel. That input comes from a control register that the parent PLL shares with all of its sibling channels. A further input reports whether the parent is producing a clock at all. Any write to the control register restarts the count, so a new ratio applies from the next parent strobe.

Top module: `pll_chan_postdiv`

## Requirements
- R1: The channel runs only while the switch-off bit `ctl_wdata[DIV_W]` (as stored) is 0, `hold_in` is 0 and `pll_live` is 1. In any other case `out_strobe` stays 0.
- R2: When `hold_in` is 1, the channel is silenced whatever the stored control value is. The hold has no place in the channel's own register.
- R3: A stored ratio field `ctl_wdata[DIV_W-1:0]` of 0 acts as the all-ones value 2^DIV_W-1.
- R4: With the channel running, the total divisor is ratio times FIXED_DIV. After the count restarts, `out_strobe` pulses for one cycle, in the cycle after the total-divisor-th `src_strobe`.
- R5: While `pll_live` is 0, parent strobes produce no output.
- R6: After each output strobe the count reloads to zero, so the output repeats every total-divisor parent strobes.
- R7: A cycle with `ctl_we` high stores `ctl_wdata` and clears the count. A `src_strobe` in that same cycle is not counted and produces no output.
- R8: In any cycle where the channel is not running, the count clears. After the channel runs again, a full total divisor of strobes is needed before the next output.
- R9: Synchronous active-high `rst` loads RST_CTL into the register, which is visible on `ctl_q`. It also clears the count and the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | DIV_W+1 | Bit DIV_W is the switch-off bit; the low DIV_W bits are the ratio |
| hold_in | input | 1 | Hold bit from the register shared with the parent PLL |
| pll_live | input | 1 | Parent PLL is producing a clock |
| src_strobe | input | 1 | One-cycle strobe per parent clock period |
| ctl_q | output | DIV_W+1 | Stored control register value |
| out_strobe | output | 1 | One-cycle channel output strobe |

## Verification
The bench builds the block with DIV_W=4 and FIXED_DIV=3. A zero ratio then gives a total divisor of 45, which a directed run reaches in under fifty strobes. The series fixed divider is also exercised, because every ratio yields a multiple of three. With the ratio field this narrow, random control writes land on the zero code and on the maximum ratio often. They also collide with counts in progress, so restarts from writes, from hold and from a lost parent clock occur at many count phases.

// File: rtl/pll_chan_postdiv.sv
module pll_chan_postdiv #(
  parameter int DIV_W = 8,
  parameter int FIXED_DIV = 1,
  parameter logic [DIV_W:0] RST_CTL = {1'b1, {DIV_W{1'b0}}}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [DIV_W:0]   ctl_wdata,
  input  logic             hold_in,
  input  logic             pll_live,
  input  logic             src_strobe,
  output logic [DIV_W:0]   ctl_q,
  output logic             out_strobe
);
  localparam int MAXDIV  = (1 << DIV_W) - 1;
  localparam int TOT_MAX = MAXDIV * FIXED_DIV;
  localparam int CW      = $clog2(TOT_MAX + 1);

  logic [DIV_W:0]   ctl_r;
  logic [CW-1:0]    cnt;
  logic             out_r;
  logic [DIV_W-1:0] eff_div;
  logic [CW-1:0]    total;
  logic             run, last;

  assign ctl_q      = ctl_r;
  assign out_strobe = out_r;
  assign eff_div    = (ctl_r[DIV_W-1:0] == '0) ? {DIV_W{1'b1}} : ctl_r[DIV_W-1:0];
  assign total      = CW'(eff_div) * CW'(FIXED_DIV);
  assign run        = !ctl_r[DIV_W] && !hold_in && pll_live;
  assign last       = (cnt == total - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_r <= RST_CTL;
      cnt   <= '0;
      out_r <= 1'b0;
    end else begin
      out_r <= 1'b0;
      if (ctl_we) begin
        ctl_r <= ctl_wdata;
        cnt   <= '0;
      end else if (!run) begin
        cnt <= '0;
      end else if (src_strobe) begin
        if (last) begin
          cnt   <= '0;
          out_r <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_GATED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[DIV_W] || hold_in || !pll_live) |=> !out_strobe); // R1
  AST_NO_SRC_NO_OUT: assert property (@(posedge clk) disable iff (rst)
    !src_strobe |=> !out_strobe); // R4
  AST_WRITE_SILENCES: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> (!out_strobe && cnt == '0)); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt < total); // R3
  AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
    out_strobe |-> cnt == '0); // R6
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!ctl_we && !run) |=> cnt == '0); // R8
  AST_RESET_LOAD: assert property (@(posedge clk)
    rst |=> (ctl_q == RST_CTL && !out_strobe)); // R9
endmodule

// File: tb/pll_chan_postdiv_test.sv
module pll_chan_postdiv_test;
  localparam int DW = 4;
  localparam int FX = 3;

  logic clk = 0, rst = 1, ctl_we = 0, hold_in = 0, pll_live = 1, src_strobe = 0;
  logic [DW:0] ctl_wdata = '0;
  logic [DW:0] ctl_q;
  logic out_strobe;

  int checks = 0, failures = 0, n_out = 0, m_cnt = 0;
  logic [DW:0] m_ctl;
  bit done = 0;

  always #5 clk = ~clk;

  pll_chan_postdiv #(.DIV_W(DW), .FIXED_DIV(FX), .RST_CTL(5'h10)) uut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .hold_in(hold_in),
    .pll_live(pll_live), .src_strobe(src_strobe), .ctl_q(ctl_q), .out_strobe(out_strobe));

  function automatic int total_div(logic [DW:0] c);
    int d = int'(c[DW-1:0]);
    if (d == 0) d = (1 << DW) - 1;
    return d * FX;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(string tag, bit we, logic [DW:0] wd, bit hd, bit lv, bit s);
    bit exp = 0, en;
    @(negedge clk);
    ctl_we = we; ctl_wdata = wd; hold_in = hd; pll_live = lv; src_strobe = s;
    en = !m_ctl[DW] && !hd && lv;
    if (we) begin m_ctl = wd; m_cnt = 0; end
    else if (!en) m_cnt = 0;
    else if (s) begin
      if (m_cnt == total_div(m_ctl) - 1) begin exp = 1; m_cnt = 0; end
      else m_cnt++;
    end
    @(posedge clk); #1;
    if (out_strobe) n_out++;
    chk(tag, int'(out_strobe), int'(exp));
    chk({tag, " ctl"}, int'(ctl_q), int'(m_ctl));
  endtask

  task automatic strobes(string tag, int n, bit hd, bit lv);
    for (int i = 0; i < n; i++) step(tag, 0, '0, hd, lv, 1);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_ctl = 5'h10;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset ctl", int'(ctl_q), 16);
    chk("R9 reset out", int'(out_strobe), 0);
    @(negedge clk); rst = 0;

    step("R3 write", 1, 5'h00, 0, 1, 0);
    n_out = 0;
    strobes("R3 div0", 44, 0, 1);
    chk("R3 before max", n_out, 0);
    strobes("R3 div0", 1, 0, 1);
    chk("R3 at max", n_out, 1);

    step("R4 write", 1, 5'h02, 0, 1, 0);
    n_out = 0;
    strobes("R4 R6 div2", 12, 0, 1);
    chk("R6 period repeats", n_out, 2);

    strobes("R7 pre", 3, 0, 1);
    n_out = 0;
    step("R7 write+strobe", 1, 5'h02, 0, 1, 1);
    strobes("R7 after", 5, 0, 1);
    chk("R7 restart", n_out, 0);
    strobes("R7 after", 1, 0, 1);
    chk("R7 full ratio", n_out, 1);

    strobes("R8 pre", 4, 0, 1);
    n_out = 0;
    step("R8 hold pulse", 0, '0, 1, 1, 1);
    strobes("R8 resume", 5, 0, 1);
    chk("R8 cleared", n_out, 0);
    strobes("R8 resume", 1, 0, 1);
    chk("R8 full ratio", n_out, 1);

    n_out = 0;
    strobes("R5 dead pll", 20, 0, 0);
    chk("R5 no out", n_out, 0);
    strobes("R2 hold", 20, 1, 1);
    chk("R2 no out", n_out, 0);
    step("R1 off write", 1, 5'h11, 0, 1, 0);
    strobes("R1 off", 20, 0, 1);
    chk("R1 no out", n_out, 0);
    step("R1 on write", 1, 5'h01, 0, 1, 0);
    strobes("R1 R4 div1", 6, 0, 1);
    chk("R4 div1 count", n_out, 2);

    for (int i = 0; i < 4000; i++) begin
      bit we = ($urandom % 40) == 0;
      logic [DW:0] wd = DW'($urandom) | (($urandom % 6 == 0) ? 5'h10 : 5'h00);
      wd[DW] = ($urandom % 6) == 0;
      step("R1-random", we, wd, ($urandom % 25) == 0, ($urandom % 30) != 0, $urandom % 2);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule